// File: doc/BRIEF.md
# Half-depth one-shot flag generator

This block keeps the write pointer of a circular buffer and raises a half-full status flag once when the pointer arrives at the midpoint of the buffer. The flag is not a level comparison. It is a registered pulse of fixed length that begins on the clock edge after the pointer first shows the threshold value. Moving the pointer while the pulse runs has no effect on it.

A new pulse needs a fresh arrival. The pointer must show some other value and then come back to the threshold. An arrival that occurs while a pulse is already running is used up at that point. It does not lengthen or restart the pulse, and it does not cause a second pulse after the first one ends.

The pointer advances by one on each write and wraps at the buffer depth. It can also be loaded directly from an external value, for example when the producer side is resynchronised. The buffer depth, the threshold and the pulse length are parameters, with defaults of 1000, 500 and 16.

Top module: `hf_half_flag`

## Requirements
- R1: When no load is requested, the pointer increments by one on each rising clock edge where `wr_en_i` is high. When `wr_en_i` is low, the pointer holds its value.
- R2: With `wr_en_i` high and no load, a pointer at DEPTH-1 wraps to 0. The pointer never shows a value of DEPTH or above.
- R3: With `ptr_ld_i` high, the pointer takes the value `ptr_ld_val_i` on the next edge, and the load wins over `wr_en_i`. A load value of DEPTH or above is ignored, and the pointer holds on that edge.
- R4: `half_full_o` rises on the clock edge that follows the first cycle in which `ptr_o` shows THRESH, given that no pulse is running.
- R5: Once risen, `half_full_o` stays high for exactly PULSE_LEN cycles (16 by default) and then falls, whether the pointer moves or holds.
- R6: While the pointer stays at THRESH after a pulse, no further pulse occurs. The trigger re-arms only after the pointer shows a value other than THRESH.
- R7: An arrival at THRESH during a running pulse, including the pulse's last cycle, is consumed. The pulse is not extended or restarted, and no pulse follows it unless the pointer leaves THRESH and returns.
- R8: Asserting `rst_ni` low clears the pointer to 0 and drives `half_full_o` low at once, whatever the current state. This includes aborting a running pulse. It also leaves the trigger armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe that advances the pointer |
| ptr_ld_i | input | 1 | Load the pointer from `ptr_ld_val_i` |
| ptr_ld_val_i | input | PTR_W (10) | Value to load into the pointer |
| ptr_o | output | PTR_W (10) | Current write pointer |
| half_full_o | output | 1 | One-shot half-full pulse |

## Verification
Two functions of the block can fall in the same cycle: the final count of a running pulse and a new arrival of the pointer at the threshold. The bench creates this case by loading the pointer away from the threshold during a pulse. It then loads the threshold back so that the value appears in exactly the pulse's last cycle. The expected result is that the flag falls on time and stays low afterwards, because that arrival is consumed. In a second run, the bench delays the return by one cycle. There the expected result is a fresh pulse starting on the following edge. These two outcomes separate a correct design from one that is off by one cycle in either direction. Load and write enable arriving together form a second coincidence, and the bench judges it by the loaded value winning.

// File: rtl/hf_pkg.sv
package hf_pkg;

  typedef enum logic [0:0] {
    PULSE_IDLE = 1'b0,
    PULSE_HOLD = 1'b1
  } pulse_st_e;

  localparam int unsigned HF_DEPTH_DEF  = 1000;
  localparam int unsigned HF_THRESH_DEF = 500;
  localparam int unsigned HF_LEN_DEF    = 16;

endpackage

// File: rtl/hf_wr_ptr.sv
module hf_wr_ptr #(
  parameter int unsigned DEPTH = hf_pkg::HF_DEPTH_DEF,
  parameter int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             ld_i,
  input  logic [PTR_W-1:0] ld_val_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam bit             POW2 = ((DEPTH & (DEPTH - 1)) == 0);
  localparam logic [PTR_W:0] LIM  = (PTR_W+1)'(DEPTH);

  logic [PTR_W-1:0] ptr_q, ptr_inc;
  logic             ld_ok;

  assign ld_ok = ({1'b0, ld_val_i} < LIM);

  generate
    if (POW2) begin : g_wrap_free
      assign ptr_inc = ptr_q + 1'b1;
    end else begin : g_wrap_cmp
      localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
      assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (ld_i) begin
      // out-of-range load holds the pointer
      if (ld_ok) ptr_q <= ld_val_i;
    end else if (wr_en_i) begin
      ptr_q <= ptr_inc;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/hf_mid_detect.sv
module hf_mid_detect #(
  parameter int unsigned PTR_W  = 10,
  parameter int unsigned THRESH = hf_pkg::HF_THRESH_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PTR_W-1:0] ptr_i,
  output logic             trig_o
);
  localparam logic [PTR_W-1:0] MID = PTR_W'(THRESH);

  logic hit, armed_q;

  assign hit = (ptr_i == MID);

  // armed means the pointer showed a non-threshold value last cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b1;
    else         armed_q <= !hit;
  end

  assign trig_o = hit && armed_q;
endmodule

// File: rtl/hf_pulse_timer.sv
module hf_pulse_timer #(
  parameter int unsigned PULSE_LEN = hf_pkg::HF_LEN_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic flag_o
);
  import hf_pkg::*;

  localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(PULSE_LEN - 1);

  pulse_st_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      PULSE_IDLE: begin
        if (trig_i) begin
          st_d  = PULSE_HOLD;
          cnt_d = CNT_INIT;
        end
      end
      PULSE_HOLD: begin
        // triggers during a pulse are dropped
        if (cnt_q == '0) st_d = PULSE_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = PULSE_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PULSE_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign flag_o = (st_q == PULSE_HOLD);
endmodule

// File: rtl/hf_half_flag.sv
module hf_half_flag #(
  parameter int unsigned DEPTH     = hf_pkg::HF_DEPTH_DEF,
  parameter int unsigned THRESH    = hf_pkg::HF_THRESH_DEF,
  parameter int unsigned PULSE_LEN = hf_pkg::HF_LEN_DEF,
  parameter int unsigned PTR_W     = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             ptr_ld_i,
  input  logic [PTR_W-1:0] ptr_ld_val_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             half_full_o
);
  logic [PTR_W-1:0] ptr;
  logic             trig;

  hf_wr_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .ld_i     (ptr_ld_i),
    .ld_val_i (ptr_ld_val_i),
    .ptr_o    (ptr)
  );

  hf_mid_detect #(.PTR_W(PTR_W), .THRESH(THRESH)) u_mid (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ptr_i  (ptr),
    .trig_o (trig)
  );

  hf_pulse_timer #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig),
    .flag_o (half_full_o)
  );

  assign ptr_o = ptr;
endmodule

// File: rtl/hf_half_flag_chk.sv
module hf_half_flag_chk #(
  parameter int unsigned DEPTH     = 1000,
  parameter int unsigned THRESH    = 500,
  parameter int unsigned PULSE_LEN = 16,
  parameter int unsigned PTR_W     = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             ptr_ld_i,
  input logic [PTR_W-1:0] ptr_ld_val_i,
  input logic [PTR_W-1:0] ptr_o,
  input logic             half_full_o
);
  localparam int unsigned RW = $clog2(PULSE_LEN + 2);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] MID  = PTR_W'(THRESH);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= '0;
    else if (half_full_o) run_q <= run_q + 1'b1;
    else                  run_q <= '0;
  end

  AST_PTR_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_ld_i && wr_en_i && ptr_o != LAST) |=> (ptr_o == $past(ptr_o) + 1'b1)); // R1
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_ld_i && !wr_en_i) |=> $stable(ptr_o)); // R1
  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_ld_i && wr_en_i && ptr_o == LAST) |=> (ptr_o == '0)); // R2
  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, ptr_o} < (PTR_W+1)'(DEPTH))); // R2
  AST_PTR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_ld_i && ({1'b0, ptr_ld_val_i} < (PTR_W+1)'(DEPTH))) |=> (ptr_o == $past(ptr_ld_val_i))); // R3
  AST_BAD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_ld_i && ({1'b0, ptr_ld_val_i} >= (PTR_W+1)'(DEPTH))) |=> $stable(ptr_o)); // R3
  AST_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!half_full_o && ptr_o == MID && $past(ptr_o) != MID) |=> half_full_o); // R4
  AST_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(half_full_o) |-> ($past(ptr_o) == MID)); // R6
  AST_PULSE_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_full_o |-> (run_q < RW'(PULSE_LEN))); // R5
  AST_PULSE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(half_full_o) |-> (run_q == RW'(PULSE_LEN))); // R7
endmodule

bind hf_half_flag hf_half_flag_chk #(
  .DEPTH(DEPTH), .THRESH(THRESH), .PULSE_LEN(PULSE_LEN), .PTR_W(PTR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .ptr_ld_i     (ptr_ld_i),
  .ptr_ld_val_i (ptr_ld_val_i),
  .ptr_o        (ptr_o),
  .half_full_o  (half_full_o)
);

// File: tb/hf_half_flag_tb_top.sv
module hf_half_flag_tb_top;
  localparam int NV = 7;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       ptr_ld_i = 1'b0;
  logic [9:0] ptr_ld_val_i = '0;
  logic [9:0] ptr_o;
  logic       half_full_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  hf_half_flag dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .ptr_ld_i     (ptr_ld_i),
    .ptr_ld_val_i (ptr_ld_val_i),
    .ptr_o        (ptr_o),
    .half_full_o  (half_full_o)
  );

  // {ld, ld_val, wr_en, exp_ptr, exp_flag}
  localparam logic [22:0] VECS [NV] = '{
    {1'b1, 10'd498, 1'b0, 10'd498, 1'b0},
    {1'b0, 10'd0,   1'b1, 10'd499, 1'b0},
    {1'b0, 10'd0,   1'b1, 10'd500, 1'b0},
    {1'b0, 10'd0,   1'b1, 10'd501, 1'b1},
    {1'b0, 10'd0,   1'b1, 10'd502, 1'b1},
    {1'b1, 10'd500, 1'b1, 10'd500, 1'b1},
    {1'b0, 10'd0,   1'b0, 10'd500, 1'b1}
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(bit ld, int val, bit we);
    ptr_ld_i     = ld;
    ptr_ld_val_i = 10'(val);
    wr_en_i      = we;
    @(negedge clk_i);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, 0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int hi;
    // R8 reset state
    @(negedge clk_i);
    chk("R8 ptr in reset", int'(ptr_o), 0);
    chk("R8 flag in reset", int'(half_full_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table: R3 load, R1 increment, R4 rise, R5 moving pointer, R3 load beats write
    for (int v = 0; v < NV; v++) begin
      drive(VECS[v][22], int'(VECS[v][21:12]), VECS[v][11]);
      chk($sformatf("R1/R3/R4/R5 vec%0d ptr", v), int'(ptr_o), int'(VECS[v][10:1]));
      chk($sformatf("R4/R5 vec%0d flag", v), int'(half_full_o), int'(VECS[v][0]));
    end
    // pulse began at vec3; 12 more high samples, then low
    hi = 0;
    for (int i = 0; i < 12; i++) begin
      drive(1'b0, 0, 1'b0);
      hi += int'(half_full_o);
    end
    chk("R5 pulse remainder high", hi, 12);
    drive(1'b0, 0, 1'b0);
    chk("R5 pulse ends after 16", int'(half_full_o), 0);
    // R7 return during pulse consumed; R6 staying at threshold gives no refire
    idle(5);
    chk("R6/R7 no refire at threshold", int'(half_full_o), 0);
    chk("R1 pointer held", int'(ptr_o), 500);

    // R6 re-arm after leaving
    drive(1'b0, 0, 1'b1);
    chk("R1 step off threshold", int'(ptr_o), 501);
    drive(1'b1, 500, 1'b0);
    chk("R4 flag low on arrival cycle", int'(half_full_o), 0);
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      drive(1'b0, 0, 1'b0);
      hi += int'(half_full_o);
    end
    chk("R6 rearmed pulse length", hi, 16);

    // R2 wrap, R3 bad load
    drive(1'b1, 998, 1'b0);
    drive(1'b0, 0, 1'b1);
    chk("R1 to last", int'(ptr_o), 999);
    drive(1'b0, 0, 1'b1);
    chk("R2 wrap to zero", int'(ptr_o), 0);
    drive(1'b0, 0, 1'b1);
    chk("R2 after wrap", int'(ptr_o), 1);
    drive(1'b1, 1000, 1'b1);
    chk("R3 out-of-range load ignored", int'(ptr_o), 1);
    drive(1'b1, 1023, 1'b0);
    chk("R3 out-of-range load max", int'(ptr_o), 1);

    // R7 arrival in last pulse cycle is consumed
    drive(1'b1, 500, 1'b0);
    drive(1'b0, 0, 1'b0);
    chk("R4 pulse start S", int'(half_full_o), 1);
    drive(1'b1, 20, 1'b0);
    idle(13);
    drive(1'b1, 500, 1'b0);
    chk("R7 last pulse cycle high", int'(half_full_o), 1);
    drive(1'b0, 0, 1'b0);
    chk("R7 pulse ends on time", int'(half_full_o), 0);
    drive(1'b0, 0, 1'b0);
    chk("R7 coincident arrival consumed", int'(half_full_o), 0);
    idle(3);
    chk("R7 still no pulse", int'(half_full_o), 0);

    // arrival one cycle after pulse end fires
    drive(1'b1, 20, 1'b0);
    drive(1'b1, 500, 1'b0);
    drive(1'b0, 0, 1'b0);
    chk("R4 second start", int'(half_full_o), 1);
    drive(1'b1, 20, 1'b0);
    idle(14);
    chk("R5 last high", int'(half_full_o), 1);
    drive(1'b1, 500, 1'b0);
    chk("R5 low at S+16", int'(half_full_o), 0);
    drive(1'b0, 0, 1'b0);
    chk("R6 late arrival fires", int'(half_full_o), 1);

    // R8 reset mid-pulse
    idle(3);
    rst_ni = 1'b0;
    #1;
    chk("R8 async flag clear", int'(half_full_o), 0);
    chk("R8 async ptr clear", int'(ptr_o), 0);
    idle(2);
    rst_ni = 1'b1;
    idle(1);
    chk("R8 flag stays low", int'(half_full_o), 0);
    drive(1'b1, 500, 1'b0);
    drive(1'b0, 0, 1'b0);
    chk("R8 armed after reset", int'(half_full_o), 1);

    finish_run();
  end
endmodule